// File: doc/BRIEF.md
# Memory and I/O Address Decoder

This block sits between a processor's 16-bit address bus and the devices hung on it. It looks at the address, a status line that says whether the current cycle is an I/O cycle or a memory cycle, and the active-low read and write strobes. From these it produces active-low chip selects and the four combined bus strobes: memory read, memory write, I/O read and I/O write.

Memory cycles divide the 64K space into eight equal zones of 8K each. The three top address bits pick the zone, and the thirteen low bits are handed on unchanged as the offset inside the selected device. I/O cycles use the upper address byte. Eight port selects can fire only when the five top bits are all ones, so the ports occupy upper-byte values F8h to FFh. The memory decoder and the I/O decoder are gated against each other by the status line, so at most one of the two groups can be active in any cycle.

By default every output is registered and lags its inputs by exactly one clock. A parameter removes the register stage and makes the block purely combinational. If read and write are both driven low together, the block holds every strobe inactive and raises an error flag.

Top module: `addr_select_unit`

## Requirements
- R1: While reset is high, and on the first output after it, every memory select, I/O select and strobe is 1, the error flag is 0 and the offset is 0.
- R2: With io_m = 0, mem_cs_n[k] is 0 for k = addr[15:13], so zone k covers addresses k*2000h to k*2000h+1FFFh. All other memory selects are 1.
- R3: With io_m = 0, exactly one memory select is 0. With io_m = 1, all memory selects are 1.
- R4: mem_offset equals addr[12:0] in every cycle type.
- R5: io_cs_n[n] is 0 only when io_m = 1, addr[15:11] = 5'b11111 and addr[10:8] = n, so port n sits at upper byte F8h+n. In every other case all I/O selects are 1, including every memory cycle.
- R6: mem_rd_n is 0 only when io_m = 0, rd_n = 0 and wr_n = 1. mem_wr_n is 0 only when io_m = 0, wr_n = 0 and rd_n = 1.
- R7: io_rd_n is 0 only when io_m = 1, rd_n = 0 and wr_n = 1. io_wr_n is 0 only when io_m = 1, wr_n = 0 and rd_n = 1. At most one of the four strobes is 0 at a time.
- R8: When rd_n and wr_n are both 0, all four strobes are 1 and bus_err is 1. The selects and the offset are decoded as usual. Otherwise bus_err is 0.
- R9: With REGISTERED = 1, every output shows the decode of the inputs sampled at the previous rising clock edge. Outputs keep their old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| io_m | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mem_cs_n | output | 8 | Active-low memory zone selects |
| io_cs_n | output | 8 | Active-low I/O port selects |
| mem_offset | output | 13 | Address bits passed to the selected memory |
| mem_rd_n | output | 1 | Active-low memory read |
| mem_wr_n | output | 1 | Active-low memory write |
| io_rd_n | output | 1 | Active-low I/O read |
| io_wr_n | output | 1 | Active-low I/O write |
| bus_err | output | 1 | Read and write were asserted together |

## Verification
The block holds no state apart from its single output register. A wrong decode therefore shows at the ports one cycle after the address that provokes it. A wrong zone or port index shows as the wrong select bit going low. A missing gate on the status line shows as a memory select and an I/O select low together. A bad I/O window shows as a port select firing at upper-byte values below F8h. A strobe or conflict fault shows as two strobes low at once, or as a strobe low while bus_err is set. The bench walks the zone edges, the window edges and every read/write pairing, and mixes these with random addresses, so each of these faults is caught within a cycle of the vector that exposes it.

// File: rtl/addr_select_pkg.sv
package addr_select_pkg;

    typedef enum logic {
        CYC_MEM = 1'b0,
        CYC_IO  = 1'b1
    } cycle_kind_e;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
        logic err;
    } strobe_set_t;

    localparam strobe_set_t STROBES_IDLE = '{
        mem_rd_n: 1'b1, mem_wr_n: 1'b1, io_rd_n: 1'b1, io_wr_n: 1'b1, err: 1'b0
    };

    function automatic logic rw_conflict(input logic rd_n, input logic wr_n);
        return !rd_n && !wr_n;
    endfunction

    function automatic strobe_set_t combine_strobes(input cycle_kind_e kind,
                                                    input logic rd_n,
                                                    input logic wr_n);
        strobe_set_t s;
        s = STROBES_IDLE;
        if (rw_conflict(rd_n, wr_n)) begin
            s.err = 1'b1;
        end else if (kind == CYC_MEM) begin
            s.mem_rd_n = rd_n;
            s.mem_wr_n = wr_n;
        end else begin
            s.io_rd_n = rd_n;
            s.io_wr_n = wr_n;
        end
        return s;
    endfunction

endpackage

// File: rtl/sel_decoder.sv
module sel_decoder #(
    parameter int SEL_BITS = 3
) (
    input  logic                       en,
    input  logic [SEL_BITS-1:0]        sel,
    output logic [(1<<SEL_BITS)-1:0]   cs_n
);
    localparam int NOUT = 1 << SEL_BITS;

    for (genvar i = 0; i < NOUT; i++) begin : g_line
        assign cs_n[i] = !(en && (sel == SEL_BITS'(i)));
    end
endmodule

// File: rtl/window_match.sv
module window_match #(
    parameter int W = 5
) (
    input  logic [W-1:0] bits,
    output logic         hit
);
    assign hit = &bits;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import addr_select_pkg::*;
(
    input  logic        io_m,
    input  logic        rd_n,
    input  logic        wr_n,
    output strobe_set_t strobes
);
    cycle_kind_e kind;

    always_comb begin
        kind    = io_m ? CYC_IO : CYC_MEM;
        strobes = combine_strobes(kind, rd_n, wr_n);
    end
endmodule

// File: rtl/output_stage.sv
module output_stage #(
    parameter int          W          = 8,
    parameter bit          REGISTERED = 1'b1,
    parameter logic [W-1:0] RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REGISTERED) begin : g_reg
        logic [W-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst) q_r <= RST_VAL;
            else     q_r <= d;
        end
        assign q = q_r;
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/addr_select_unit.sv
module addr_select_unit
    import addr_select_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ZONE_BITS  = 3,
    parameter int PORT_BITS  = 3,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          io_m,
    input  logic                          rd_n,
    input  logic                          wr_n,
    output logic [(1<<ZONE_BITS)-1:0]     mem_cs_n,
    output logic [(1<<PORT_BITS)-1:0]     io_cs_n,
    output logic [ADDR_W-ZONE_BITS-1:0]   mem_offset,
    output logic                          mem_rd_n,
    output logic                          mem_wr_n,
    output logic                          io_rd_n,
    output logic                          io_wr_n,
    output logic                          bus_err
);
    localparam int NZONE   = 1 << ZONE_BITS;
    localparam int NPORT   = 1 << PORT_BITS;
    localparam int OFF_W   = ADDR_W - ZONE_BITS;
    localparam int IO_LSB  = ADDR_W / 2;
    localparam int WIN_LSB = IO_LSB + PORT_BITS;
    localparam int WIN_W   = ADDR_W - WIN_LSB;
    localparam int STB_W   = $bits(strobe_set_t);
    localparam int PIPE_W  = NZONE + NPORT + OFF_W + STB_W;
    localparam logic [PIPE_W-1:0] PIPE_RST =
        {{NZONE{1'b1}}, {NPORT{1'b1}}, {OFF_W{1'b0}}, STROBES_IDLE};

    logic              win_hit;
    logic              io_en;
    logic [NZONE-1:0]  zone_cs_n;
    logic [NPORT-1:0]  port_cs_n;
    strobe_set_t       stb;
    strobe_set_t       stb_q;
    logic [PIPE_W-1:0] pipe_d;
    logic [PIPE_W-1:0] pipe_q;

    sel_decoder #(.SEL_BITS(ZONE_BITS)) u_mem_dec (
        .en   (!io_m),
        .sel  (addr[ADDR_W-1 -: ZONE_BITS]),
        .cs_n (zone_cs_n)
    );

    window_match #(.W(WIN_W)) u_io_win (
        .bits (addr[ADDR_W-1 -: WIN_W]),
        .hit  (win_hit)
    );

    assign io_en = io_m && win_hit;

    sel_decoder #(.SEL_BITS(PORT_BITS)) u_io_dec (
        .en   (io_en),
        .sel  (addr[IO_LSB +: PORT_BITS]),
        .cs_n (port_cs_n)
    );

    strobe_gen u_stb (
        .io_m    (io_m),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .strobes (stb)
    );

    assign pipe_d = {zone_cs_n, port_cs_n, addr[OFF_W-1:0], stb};

    output_stage #(
        .W          (PIPE_W),
        .REGISTERED (REGISTERED),
        .RST_VAL    (PIPE_RST)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .d   (pipe_d),
        .q   (pipe_q)
    );

    assign {mem_cs_n, io_cs_n, mem_offset, stb_q} = pipe_q;
    assign mem_rd_n = stb_q.mem_rd_n;
    assign mem_wr_n = stb_q.mem_wr_n;
    assign io_rd_n  = stb_q.io_rd_n;
    assign io_wr_n  = stb_q.io_wr_n;
    assign bus_err  = stb_q.err;
endmodule

// File: rtl/addr_select_chk.sv
module addr_select_chk #(
    parameter int ADDR_W    = 16,
    parameter int ZONE_BITS = 3,
    parameter int PORT_BITS = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           addr,
    input logic                        io_m,
    input logic                        rd_n,
    input logic                        wr_n,
    input logic [(1<<ZONE_BITS)-1:0]   mem_cs_n,
    input logic [(1<<PORT_BITS)-1:0]   io_cs_n,
    input logic                        mem_rd_n,
    input logic                        mem_wr_n,
    input logic                        io_rd_n,
    input logic                        io_wr_n,
    input logic                        bus_err
);
    localparam int WIN_W = ADDR_W - ADDR_W/2 - PORT_BITS;

    AST_MEM_ONE_ZONE: assert property (@(posedge clk) disable iff (rst)
        !io_m |=> $countones(~mem_cs_n) == 1);                                   // R3
    AST_MEM_ZONE_IDX: assert property (@(posedge clk) disable iff (rst)
        !io_m |=> mem_cs_n[$past(addr[ADDR_W-1 -: ZONE_BITS])] == 1'b0);         // R2
    AST_MEM_QUIET_IO: assert property (@(posedge clk) disable iff (rst)
        io_m |=> &mem_cs_n);                                                     // R3
    AST_IO_QUIET_MEM: assert property (@(posedge clk) disable iff (rst)
        !io_m |=> &io_cs_n);                                                     // R5
    AST_IO_OUT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (io_m && !(&addr[ADDR_W-1 -: WIN_W])) |=> &io_cs_n);                     // R5
    AST_RW_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |=> (bus_err && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 1);             // R7
    AST_NO_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rd_n || wr_n) |=> !bus_err);                                            // R8
endmodule

bind addr_select_unit addr_select_chk #(
    .ADDR_W    (ADDR_W),
    .ZONE_BITS (ZONE_BITS),
    .PORT_BITS (PORT_BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .io_m     (io_m),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .mem_cs_n (mem_cs_n),
    .io_cs_n  (io_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .bus_err  (bus_err)
);

// File: tb/addr_select_unit_bench.sv
`timescale 1ns/1ps
module addr_select_unit_bench;

    typedef struct packed {
        logic [7:0]  mcs;
        logic [7:0]  ics;
        logic [12:0] off;
        logic        mrd;
        logic        mwr;
        logic        ird;
        logic        iwr;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        io_m = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  mem_cs_n;
    logic [7:0]  io_cs_n;
    logic [12:0] mem_offset;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, bus_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    addr_select_unit u_addr_select_unit (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .io_m       (io_m),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .mem_cs_n   (mem_cs_n),
        .io_cs_n    (io_cs_n),
        .mem_offset (mem_offset),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .bus_err    (bus_err)
    );

    function automatic exp_t model(input logic [15:0] a, input logic iom,
                                   input logic rd, input logic wr);
        exp_t e;
        logic clash;
        clash = !rd && !wr;
        e.mcs = 8'hFF;
        e.ics = 8'hFF;
        if (!iom) e.mcs[a[15:13]] = 1'b0;                  // R2 R3
        if (iom && a[15:11] == 5'b11111) e.ics[a[10:8]] = 1'b0; // R5
        e.off = a[12:0];                                   // R4
        e.mrd = !(!iom && !rd && !clash);                  // R6
        e.mwr = !(!iom && !wr && !clash);
        e.ird = !(iom && !rd && !clash);                   // R7
        e.iwr = !(iom && !wr && !clash);
        e.err = clash;                                     // R8
        return e;
    endfunction

    function automatic exp_t actual();
        return '{mcs: mem_cs_n, ics: io_cs_n, off: mem_offset, mrd: mem_rd_n,
                 mwr: mem_wr_n, ird: io_rd_n, iwr: io_wr_n, err: bus_err};
    endfunction

    task automatic check(input string req, input exp_t exp);
        exp_t act;
        act = actual();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h io_m=%b rd_n=%b wr_n=%b actual=%h expected=%h",
                     req, addr, io_m, rd_n, wr_n, act, exp);
        end
    endtask

    exp_t last_exp;

    task automatic apply(input string req, input logic [15:0] a, input logic iom,
                         input logic rd, input logic wr);
        exp_t e;
        @(negedge clk);
        addr = a; io_m = iom; rd_n = rd; wr_n = wr;
        #1;
        check("R9 hold", last_exp);   // R9: no change before the edge
        e = model(a, iom, rd, wr);
        @(negedge clk);
        check(req, e);
        last_exp = e;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        last_exp = '{mcs: 8'hFF, ics: 8'hFF, off: 13'h0, mrd: 1'b1,
                     mwr: 1'b1, ird: 1'b1, iwr: 1'b1, err: 1'b0};
        addr = 16'hFFFF; io_m = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", last_exp);
        @(negedge clk);
        rst = 1'b0;
        addr = 16'h0000; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        last_exp = model(addr, io_m, rd_n, wr_n);
        check("R1 first out", last_exp);

        // R2 zone boundaries
        apply("R2 zone0 low",  16'h0000, 1'b0, 1'b0, 1'b1);
        apply("R2 zone0 high", 16'h1FFF, 1'b0, 1'b1, 1'b0);
        apply("R2 zone1 low",  16'h2000, 1'b0, 1'b0, 1'b1);
        apply("R2 zone6 high", 16'hDFFF, 1'b0, 1'b1, 1'b1);
        apply("R2 zone7 low",  16'hE000, 1'b0, 1'b1, 1'b0);
        apply("R4 zone7 top",  16'hFFFF, 1'b0, 1'b0, 1'b1);
        // R3 memory selects idle during I/O
        apply("R3 io cycle",   16'h4123, 1'b1, 1'b0, 1'b1);
        // R5 I/O window edges and every port
        for (int p = 0; p < 8; p++)
            apply("R5 port", {5'b11111, 3'(p), 8'h5A}, 1'b1, 1'b1, 1'b0);
        apply("R5 below window", 16'hF7FF, 1'b1, 1'b0, 1'b1);
        apply("R5 low byte",     16'h07FF, 1'b1, 1'b0, 1'b1);
        apply("R5 mem at F8",    16'hF800, 1'b0, 1'b0, 1'b1);
        // R6 R7 strobe pairings
        apply("R6 mem idle",  16'h8000, 1'b0, 1'b1, 1'b1);
        apply("R7 io write",  16'hFB00, 1'b1, 1'b1, 1'b0);
        apply("R7 io read",   16'hFC00, 1'b1, 1'b0, 1'b1);
        // R8 conflicts
        apply("R8 mem clash", 16'h6000, 1'b0, 1'b0, 1'b0);
        apply("R8 io clash",  16'hFD10, 1'b1, 1'b0, 1'b0);
        apply("R8 recover",   16'h6000, 1'b0, 1'b0, 1'b1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic iom, rd, wr;
            a   = 16'($urandom);
            if ($urandom_range(0, 3) == 0) a[15:11] = 5'b11111;
            iom = 1'($urandom);
            rd  = 1'($urandom);
            wr  = 1'($urandom);
            apply("R2-R8 random", a, iom, rd, wr);
        end

        // reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        last_exp = '{mcs: 8'hFF, ics: 8'hFF, off: 13'h0, mrd: 1'b1,
                     mwr: 1'b1, ird: 1'b1, iwr: 1'b1, err: 1'b0};
        check("R1 reapplied", last_exp);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule